// File: doc/BRIEF.md
# Baud Clock Source Selector

This block chooses which of several reference clocks best serves a requested serial bit rate. Given a baud rate, it walks a table of candidate clock frequencies. Each candidate is divided down by a 16x oversampling factor and then by an integer divisor rounded to the nearest whole number. The block keeps the candidate whose resulting rate deviates least from the request, and reports the chosen table index, the divisor, the deviation in hundredths of a percent and the rate actually achieved. It also flags a request that no candidate can reach, and a deviation too large for reliable reception.

A single shared iterative divider does every division. A search therefore takes a few hundred cycles and is driven by a start/done handshake. The control is one state machine with these states. `S_IDLE` waits for start. `S_FETCH` looks up the current table slot. `S_QUOT` computes the rounded divisor. `S_HIRES` computes the scaled achieved rate. `S_ERR` computes the rounded deviation and compares it with the best so far. `S_ADVANCE` steps to the next slot or ends the scan. `S_ACTUAL` divides the winner's oversampled rate by its divisor. `S_DONE` is a one-cycle completion state.

The transitions are as follows. `S_IDLE` goes to `S_FETCH` on start, or straight to `S_DONE` when the baud is zero. `S_FETCH` goes to `S_QUOT` for a present slot and to `S_ADVANCE` for an absent one. `S_QUOT` goes to `S_HIRES`, or to `S_ADVANCE` when the divisor is zero. `S_HIRES` goes to `S_ERR`, and `S_ERR` goes to `S_ADVANCE`. `S_ADVANCE` goes to `S_FETCH` while slots remain. After the last slot it goes to `S_ACTUAL` if any candidate qualified, and to `S_DONE` if none did. `S_ACTUAL` goes to `S_DONE`, and `S_DONE` returns to `S_IDLE`.

Top module: `bcs_selector`

## Requirements
- R1: A start with a baud of zero performs no search. `done` rises on the first clock edge after the start edge, with `too_fast`=1 and `err_warn`=0. `sel_idx`, `divisor`, `err_cent` and `actual_baud` keep their previous values.
- R2: For each slot, the oversampled rate is the clock frequency integer-divided by 16. The divisor is (rate + baud/2) / baud, using integer division.
- R3: The error of a slot is (|floor(rate*10000/divisor) - baud*10000| + baud/2) / baud, using integer division. The unit is 0.01 percent.
- R4: The slot with the smallest error is selected. A later slot replaces the current best only if its error is strictly smaller, so on a tie the lowest index wins. `sel_idx` is the zero-based table index; with the default table, 0=81 MHz, 1=108 MHz, 2=64 MHz and 3=48 MHz.
- R5: A table slot holding frequency zero is never selected and is skipped.
- R6: A slot whose rounded divisor is zero is skipped. If no slot qualifies, `too_fast`=1 and `err_warn`=0, and `sel_idx`, `divisor`, `err_cent` and `actual_baud` keep their previous values.
- R7: After a successful search, `err_warn`=1 exactly when `err_cent` is greater than 300.
- R8: `actual_baud` equals floor(floor(clock/16) / divisor) for the selected slot.
- R9: `done` is high for exactly one cycle per search, and `busy` is high from the edge that accepts start until `done` falls. The baud is captured at that edge, and a start raised while `busy` is ignored. All result outputs hold their values between searches.
- R10: After reset, `busy`, `done`, `sel_idx`, `divisor`, `err_cent`, `actual_baud`, `too_fast` and `err_warn` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only when idle) |
| baud | input | 32 | Requested bit rate in bits per second |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| sel_idx | output | IDX_W (2) | Index of the chosen clock slot |
| divisor | output | 32 | Rounded divisor for the chosen slot |
| err_cent | output | 16 | Deviation in 0.01 percent |
| actual_baud | output | 32 | Achieved bit rate |
| too_fast | output | 1 | No slot can reach the requested rate |
| err_warn | output | 1 | Deviation above 3.00 percent |

## Verification
The divider assertion assumes that its divisor operand is never zero. The state machine guarantees this by launching divisions only with a nonzero latched baud or a nonzero rounded divisor, and the stimulus additionally includes a zero-baud request to confirm that path bypasses the divider. The achieved-rate and selection assertions assume that the clock table is held constant while running, which the bench respects because it only sets the table through parameters. Stimulus holds `start` for a single cycle except in one deliberate overlap that pulses it while a search is running.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_QUOT,
        S_HIRES,
        S_ERR,
        S_ADVANCE,
        S_ACTUAL,
        S_DONE
    } bcs_state_e;

    localparam int unsigned PCT_SCALE = 10000;

endpackage

// File: rtl/bcs_divider.sv
module bcs_divider #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);
    localparam int PW = 2 * W;

    logic [W-1:0]  acc;
    logic [W-1:0]  rem;
    logic [W-1:0]  num_l;
    logic [W-1:0]  den_l;
    logic [CW-1:0] cnt;
    logic [W:0]    shifted;

    assign shifted = {rem, acc[W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            acc   <= '0;
            rem   <= '0;
            num_l <= '0;
            den_l <= '0;
            cnt   <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                busy  <= 1'b1;
                acc   <= num;
                rem   <= '0;
                num_l <= num;
                den_l <= den;
                cnt   <= '0;
            end else if (busy) begin
                if (shifted >= {1'b0, den_l}) begin
                    rem <= W'(shifted - {1'b0, den_l});
                    acc <= {acc[W-2:0], 1'b1};
                end else begin
                    rem <= shifted[W-1:0];
                    acc <= {acc[W-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = acc;

    // Quotient bracket supports the rounding rules of R2 and R3
    p_quot_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((PW'(quo) * PW'(den_l) <= PW'(num_l)) &&
                  (PW'(num_l) < (PW'(quo) + 1'b1) * PW'(den_l))));

endmodule

// File: rtl/bcs_clk_table.sv
module bcs_clk_table #(
    parameter int N_CLK    = 4,
    parameter int IDX_W    = 2,
    parameter int OSR_LOG2 = 4,
    parameter logic [N_CLK-1:0][31:0] CLK_HZ = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      osr_rate,
    output logic             present
);
    logic [N_CLK-1:0][31:0] rate_arr;
    logic [N_CLK-1:0]       pres_arr;

    for (genvar g = 0; g < N_CLK; g++) begin : g_slot
        assign rate_arr[g] = CLK_HZ[g] >> OSR_LOG2;
        assign pres_arr[g] = (CLK_HZ[g] != 32'd0);
    end

    always_comb begin
        osr_rate = '0;
        present  = 1'b0;
        for (int i = 0; i < N_CLK; i++) begin
            if (idx == IDX_W'(i)) begin
                osr_rate = rate_arr[i];
                present  = pres_arr[i];
            end
        end
    end

endmodule

// File: rtl/bcs_selector.sv
module bcs_selector
    import bcs_pkg::*;
#(
    parameter int N_CLK     = 4,
    parameter logic [N_CLK-1:0][31:0] CLK_HZ = {32'd48_000_000, 32'd64_000_000,
                                                32'd108_000_000, 32'd81_000_000},
    parameter int OSR_LOG2  = 4,
    parameter int DW        = 48,
    parameter int ERR_LIMIT = 300,
    localparam int IDX_W    = $clog2(N_CLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      baud,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] sel_idx,
    output logic [31:0]      divisor,
    output logic [15:0]      err_cent,
    output logic [31:0]      actual_baud,
    output logic             too_fast,
    output logic             err_warn
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CLK - 1);

    bcs_state_e state, nxt;

    logic [31:0]      baud_q;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    cur_q;
    logic             found;
    logic [IDX_W-1:0] best_idx;
    logic [DW-1:0]    best_q;
    logic [DW-1:0]    best_err;

    logic [31:0]   rate_cur, rate_best, rate_sel;
    logic          pres_cur, pres_best, pres_sel;
    logic          div_go, div_busy, div_done;
    logic [DW-1:0] div_num, div_den, div_q;
    logic [DW-1:0] target, delta, half_baud;

    bcs_clk_table #(.N_CLK(N_CLK), .IDX_W(IDX_W), .OSR_LOG2(OSR_LOG2), .CLK_HZ(CLK_HZ))
        u_tab_cur  (.idx(idx),      .osr_rate(rate_cur),  .present(pres_cur));
    bcs_clk_table #(.N_CLK(N_CLK), .IDX_W(IDX_W), .OSR_LOG2(OSR_LOG2), .CLK_HZ(CLK_HZ))
        u_tab_best (.idx(best_idx), .osr_rate(rate_best), .present(pres_best));
    bcs_clk_table #(.N_CLK(N_CLK), .IDX_W(IDX_W), .OSR_LOG2(OSR_LOG2), .CLK_HZ(CLK_HZ))
        u_tab_sel  (.idx(sel_idx),  .osr_rate(rate_sel),  .present(pres_sel));

    bcs_divider #(.W(DW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .busy (div_busy),
        .done (div_done),
        .quo  (div_q)
    );

    assign half_baud = DW'(baud_q >> 1);
    assign target    = DW'(baud_q) * DW'(PCT_SCALE);
    assign delta     = (div_q > target) ? (div_q - target) : (target - div_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = (baud == 32'd0) ? S_DONE : S_FETCH;
            S_FETCH:   nxt = pres_cur ? S_QUOT : S_ADVANCE;
            S_QUOT:    if (div_done) nxt = (div_q == '0) ? S_ADVANCE : S_HIRES;
            S_HIRES:   if (div_done) nxt = S_ERR;
            S_ERR:     if (div_done) nxt = S_ADVANCE;
            S_ADVANCE: if (idx == LAST_IDX) nxt = found ? S_ACTUAL : S_DONE;
                       else nxt = S_FETCH;
            S_ACTUAL:  if (div_done) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // Divider operand selection
    always_comb begin
        div_go  = 1'b0;
        div_num = '0;
        div_den = '0;
        case (state)
            S_FETCH: if (pres_cur) begin
                div_go  = 1'b1;
                div_num = DW'(rate_cur) + half_baud;
                div_den = DW'(baud_q);
            end
            S_QUOT: if (div_done && div_q != '0) begin
                div_go  = 1'b1;
                div_num = DW'(rate_cur) * DW'(PCT_SCALE);
                div_den = div_q;
            end
            S_HIRES: if (div_done) begin
                div_go  = 1'b1;
                div_num = delta + half_baud;
                div_den = DW'(baud_q);
            end
            S_ADVANCE: if (idx == LAST_IDX && found) begin
                div_go  = 1'b1;
                div_num = DW'(rate_best);
                div_den = best_q;
            end
            default: ;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_q      <= '0;
            idx         <= '0;
            cur_q       <= '0;
            found       <= 1'b0;
            best_idx    <= '0;
            best_q      <= '0;
            best_err    <= '1;
            sel_idx     <= '0;
            divisor     <= '0;
            err_cent    <= '0;
            actual_baud <= '0;
            too_fast    <= 1'b0;
            err_warn    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    baud_q   <= baud;
                    idx      <= '0;
                    found    <= 1'b0;
                    best_err <= '1;
                    if (baud == 32'd0) begin
                        too_fast <= 1'b1;
                        err_warn <= 1'b0;
                    end
                end
                S_QUOT: if (div_done) cur_q <= div_q;
                S_ERR: if (div_done && div_q < best_err) begin
                    found    <= 1'b1;
                    best_idx <= idx;
                    best_q   <= cur_q;
                    best_err <= div_q;
                end
                S_ADVANCE: begin
                    if (idx != LAST_IDX) begin
                        idx <= idx + 1'b1;
                    end else if (!found) begin
                        too_fast <= 1'b1;
                        err_warn <= 1'b0;
                    end
                end
                S_ACTUAL: if (div_done) begin
                    sel_idx     <= best_idx;
                    divisor     <= best_q[31:0];
                    err_cent    <= best_err[15:0];
                    actual_baud <= div_q[31:0];
                    too_fast    <= 1'b0;
                    err_warn    <= (best_err > DW'(ERR_LIMIT));
                end
                default: ;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_DONE);

    p_zero_baud_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && baud == 32'd0) |=> (done && too_fast));

    p_sel_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !too_fast) |-> pres_sel);

    p_best_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACTUAL) |-> pres_best);

    p_warn_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_warn) |-> (!too_fast && err_cent > 16'(ERR_LIMIT)));

    p_warn_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !too_fast && err_cent > 16'(ERR_LIMIT)) |-> err_warn);

    p_actual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !too_fast) |->
            ((64'(actual_baud) * 64'(divisor) <= 64'(rate_sel)) &&
             (64'(rate_sel) < (64'(actual_baud) + 64'd1) * 64'(divisor))));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=>
            $stable({sel_idx, divisor, err_cent, actual_baud, too_fast, err_warn}));

    p_div_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !div_busy);

endmodule

// File: tb/bcs_selector_tb_top.sv
`timescale 1ns/1ps
module bcs_selector_tb_top;

    typedef struct packed {
        logic [31:0] baud;
        logic        tf;
        logic [1:0]  idx;
        logic [31:0] dv;
        logic [15:0] err;
        logic [31:0] act;
        logic        warn;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'd115200,   1'b0, 2'd0, 32'd44,  16'd12,   32'd115056,  1'b0},
        '{32'd9600,     1'b0, 2'd1, 32'd703, 16'd2,    32'd9601,    1'b0},
        '{32'd3000000,  1'b0, 2'd3, 32'd1,   16'd0,    32'd3000000, 1'b0},
        '{32'd1500000,  1'b0, 2'd3, 32'd2,   16'd0,    32'd1500000, 1'b0},
        '{32'd250000,   1'b0, 2'd1, 32'd27,  16'd0,    32'd250000,  1'b0},
        '{32'd5500000,  1'b0, 2'd0, 32'd1,   16'd795,  32'd5062500, 1'b1},
        '{32'd20000000, 1'b1, 2'd0, 32'd1,   16'd795,  32'd5062500, 1'b0},
        '{32'd13500000, 1'b0, 2'd1, 32'd1,   16'd5000, 32'd6750000, 1'b1},
        '{32'd13500001, 1'b1, 2'd1, 32'd1,   16'd5000, 32'd6750000, 1'b0},
        '{32'd4000000,  1'b0, 2'd2, 32'd1,   16'd0,    32'd4000000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, start2;
    logic [31:0] baud, baud2;
    logic        busy, done, tf, warn;
    logic        busy2, done2, tf2, warn2;
    logic [1:0]  sel, sel2;
    logic [31:0] dv, act, dv2, act2;
    logic [15:0] err, err2;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    bcs_selector dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .baud(baud),
        .busy(busy), .done(done), .sel_idx(sel), .divisor(dv),
        .err_cent(err), .actual_baud(act), .too_fast(tf), .err_warn(warn)
    );

    bcs_selector #(.CLK_HZ({32'd48_000_000, 32'd0, 32'd108_000_000, 32'd81_000_000}))
    dut2_i (
        .clk(clk), .rst_n(rst_n), .start(start2), .baud(baud2),
        .busy(busy2), .done(done2), .sel_idx(sel2), .divisor(dv2),
        .err_cent(err2), .actual_baud(act2), .too_fast(tf2), .err_warn(warn2)
    );

    task automatic chk(input string req, input string what,
                       input longint actual, input longint expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Called at a negedge; returns at the negedge where done is seen
    task automatic launch(input logic [31:0] b, output int cyc);
        baud  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R9", "done seen", longint'(done), 1);
    endtask

    task automatic check_vec(input vec_t v, input int n);
        chk("R6", $sformatf("row %0d too_fast", n), longint'(tf), longint'(v.tf));
        chk("R4", $sformatf("row %0d sel_idx", n), longint'(sel), longint'(v.idx));
        chk("R2", $sformatf("row %0d divisor", n), longint'(dv), longint'(v.dv));
        chk("R3", $sformatf("row %0d err_cent", n), longint'(err), longint'(v.err));
        chk("R8", $sformatf("row %0d actual_baud", n), longint'(act), longint'(v.act));
        chk("R7", $sformatf("row %0d err_warn", n), longint'(warn), longint'(v.warn));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int cyc;
        rst_n = 1'b0; start = 1'b0; start2 = 1'b0; baud = '0; baud2 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10", "busy", longint'(busy), 0);
        chk("R10", "done", longint'(done), 0);
        chk("R10", "sel_idx", longint'(sel), 0);
        chk("R10", "divisor", longint'(dv), 0);
        chk("R10", "err_cent", longint'(err), 0);
        chk("R10", "actual_baud", longint'(act), 0);
        chk("R10", "too_fast", longint'(tf), 0);
        chk("R10", "err_warn", longint'(warn), 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].baud, cyc);
            check_vec(VECS[i], i);
            @(negedge clk);
            chk("R9", "done one cycle", longint'(done), 0);
            chk("R9", "busy after done", longint'(busy), 0);
        end

        // R9 outputs hold while idle
        repeat (20) @(negedge clk);
        check_vec(VECS[NV-1], 99);

        // R1 zero baud: immediate reject, selection unchanged
        launch(32'd0, cyc);
        chk("R1", "latency", longint'(cyc), 0);
        chk("R1", "too_fast", longint'(tf), 1);
        chk("R1", "err_warn", longint'(warn), 0);
        chk("R1", "sel_idx kept", longint'(sel), 2);
        chk("R1", "divisor kept", longint'(dv), 1);
        chk("R1", "err_cent kept", longint'(err), 0);
        chk("R1", "actual kept", longint'(act), 4000000);
        @(negedge clk);

        // R9 start while busy is ignored and baud is captured at start
        baud = 32'd9600;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy during search", longint'(busy), 1);
        repeat (5) @(negedge clk);
        baud = 32'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        check_vec(VECS[1], 100);
        @(negedge clk);
        chk("R9", "no second search", longint'(busy), 0);
        repeat (3) @(negedge clk);
        chk("R9", "no late done", longint'(done), 0);

        // R5 absent slot skipped (slot 2 zero in dut2_i)
        baud2 = 32'd4000000;
        start2 = 1'b1;
        @(negedge clk);
        start2 = 1'b0;
        cyc = 0;
        while (!done2 && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R5", "dut2 done", longint'(done2), 1);
        chk("R5", "dut2 sel_idx", longint'(sel2), 1);
        chk("R5", "dut2 divisor", longint'(dv2), 2);
        chk("R5", "dut2 err_cent", longint'(err2), 1563);
        chk("R5", "dut2 actual", longint'(act2), 3375000);
        chk("R5", "dut2 err_warn", longint'(warn2), 1);
        chk("R5", "dut2 too_fast", longint'(tf2), 0);

        @(negedge clk);
        finish_run();
    end

endmodule